// File: doc/BRIEF.md
# Zoned Fully Associative Address Translator

This block turns a 32-bit effective address into a real address by searching a small, fully associative translation table in a single lookup. Each table entry carries its own page size, an optional process-ID tag and a 4-bit zone selector. The zone selector picks a 2-bit override code from a 32-bit zone protection word supplied by the core. The override can refuse user-mode access outright, defer to the entry's own execute and write bits, or grant full access whatever those bits say.

A lookup is started by a one-cycle request strobe. The result appears on registered outputs one cycle later: a hit flag, the matching entry index, the real address, the granted read and write permissions and a fault class. When no entry matches, the block reports an instruction-miss or data-miss fault. It also captures the faulting address and an exception status word, and it returns the machine state word with its upper half cleared for the exception handler. Entries are loaded through a simple write port, one entry per cycle.

Top module: `ztlb_xlate`

## Requirements
- R1: Only entries whose valid bit is set take part in matching; when several valid entries match, the lowest index is reported on `rsp_idx` and supplies the translation.
- R2: An entry whose stored process ID is 0 matches any `cur_pid`; an entry with any other stored ID matches only when it equals `cur_pid`.
- R3: For size code s (0 to 7) the page holds 1024·4^s bytes, and the compare mask is ~(page bytes − 1). The effective address under that mask must equal the stored page number, which is itself stored already masked.
- R4: On a hit, `rsp_ra` is the stored real page number under the mask OR'd with the effective-address bits outside the mask.
- R5: The matched entry's zone field z (0 to 15) selects the override code at bits [31−2z : 30−2z] of `zone_prot`, so zone 0 reads bits [31:30] and zone 15 reads bits [1:0].
- R6: Code 0 with `req_user`=1 refuses the access: `rsp_fault` is 3 for a fetch or 4 for a data access, and `rsp_rd`=`rsp_wr`=0. Code 0 in supervisor mode behaves like codes 1 and 2. Every fault reports no permissions.
- R7: Under codes 1 and 2, a fetch requires the entry's execute bit and a data store requires its write bit; a data load is always allowed. A refused access gives fault 3 (fetch) or 4 (data). An allowed access gives fault 0 with `rsp_rd`=1 and `rsp_wr` equal to the entry's write bit.
- R8: Code 3 allows every access kind with `rsp_rd`=`rsp_wr`=1, whatever the entry's execute and write bits are.
- R9: A lookup that matches no entry returns `rsp_hit`=0, `rsp_idx`=0, `rsp_ra`=0, no permissions, and `rsp_fault`=1 for a fetch or 2 for a data access. On a miss, `fault_addr` captures the effective address; it holds its value otherwise.
- R10: On a miss, `fault_status` becomes 0x00800000 for a data store and 0 for a data load or a fetch; it holds its value otherwise.
- R11: On a miss, `msr_out` is `msr_in` with bits [31:16] cleared; on any other lookup it equals `msr_in`.
- R12: `rsp_valid` is high exactly in the cycle after each `req` cycle, and all response outputs hold between lookups. After reset every output is 0 and every entry is invalid.
- R13: A lookup in the same cycle as an entry write sees the table as it was before that write; the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | IDXW | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_size | input | 3 | Page size code |
| wr_pid | input | PIDW | Process ID tag (0 = any process) |
| wr_zone | input | 4 | Zone selector |
| wr_epn | input | 32 | Effective page address (masked on store) |
| wr_rpn | input | 32 | Real page address |
| wr_exec | input | 1 | Execute permission bit |
| wr_write | input | 1 | Write permission bit |
| req | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_store | input | 1 | Data store when req_fetch is 0 |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | PIDW | Current process ID |
| zone_prot | input | 32 | Zone protection word, 2 bits per zone |
| msr_in | input | 32 | Current machine state word |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | IDXW | Index of the matching entry |
| rsp_ra | output | 32 | Real address |
| rsp_rd | output | 1 | Read permission granted |
| rsp_wr | output | 1 | Write permission granted |
| rsp_fault | output | 3 | 0 none, 1 fetch miss, 2 data miss, 3 fetch protection, 4 data protection |
| fault_addr | output | 32 | Effective address of the last miss |
| fault_status | output | 32 | Status word of the last miss |
| msr_out | output | 32 | Machine state word for the handler |

## Verification
An entry write and a lookup can fall in the same cycle, possibly on the very entry the lookup would match. The bench provokes this on purpose. It rewrites or invalidates a matching entry in the same cycle as a lookup of its page and expects the old translation. It then expects the new result on the following lookup. Random traffic mixes writes and lookups without any spacing, so such same-cycle overlaps also occur by chance. Each one is judged against a bench model that evaluates the lookup before it applies the write.

// File: rtl/ztlb_pkg.sv
package ztlb_pkg;

  localparam int PG_SH_MIN = 10;
  localparam int SZ_W      = 3;
  localparam int ZONE_W    = 4;
  localparam logic [31:0] STORE_MISS_STATUS = 32'h0080_0000;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_IMISS = 3'd1,
    FLT_DMISS = 3'd2,
    FLT_IPROT = 3'd3,
    FLT_DPROT = 3'd4
  } fault_e;

  // page of 1 KiB * 4^sz; mask keeps the page-number bits
  function automatic logic [31:0] page_mask(input logic [SZ_W-1:0] sz);
    logic [5:0] sh;
    sh = 6'(PG_SH_MIN) + {2'b00, sz, 1'b0};
    return ~((32'd1 << sh) - 32'd1);
  endfunction

endpackage

// File: rtl/ztlb_entry_store.sv
module ztlb_entry_store
  import ztlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic              wr_valid,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [PIDW-1:0]   wr_pid,
  input  logic [ZONE_W-1:0] wr_zone,
  input  logic [31:0]       wr_epn,
  input  logic [31:0]       wr_rpn,
  input  logic              wr_exec,
  input  logic              wr_write,
  output logic              valid_q [ENTRIES],
  output logic [SZ_W-1:0]   size_q  [ENTRIES],
  output logic [PIDW-1:0]   pid_q   [ENTRIES],
  output logic [ZONE_W-1:0] zone_q  [ENTRIES],
  output logic [31:0]       epn_q   [ENTRIES],
  output logic [31:0]       rpn_q   [ENTRIES],
  output logic              exec_q  [ENTRIES],
  output logic              write_q [ENTRIES]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (wr_idx == IDXW'(i)) valid_q[i] <= wr_valid;
    end
  end

  // payload needs no reset: it is ignored while the valid bit is clear
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDXW'(i)) begin
          size_q[i]  <= wr_size;
          pid_q[i]   <= wr_pid;
          zone_q[i]  <= wr_zone;
          epn_q[i]   <= wr_epn & page_mask(wr_size);
          rpn_q[i]   <= wr_rpn;
          exec_q[i]  <= wr_exec;
          write_q[i] <= wr_write;
        end
      end
    end
  end

endmodule

// File: rtl/ztlb_entry_match.sv
module ztlb_entry_match
  import ztlb_pkg::*;
#(
  parameter int PIDW = 8
) (
  input  logic            valid,
  input  logic [SZ_W-1:0] size,
  input  logic [PIDW-1:0] pid,
  input  logic [31:0]     epn,
  input  logic [31:0]     rpn,
  input  logic [31:0]     ea,
  input  logic [PIDW-1:0] cur_pid,
  output logic            hit,
  output logic [31:0]     ra
);

  logic [31:0] mask;
  logic        pid_ok;

  always_comb begin
    mask   = page_mask(size);
    pid_ok = (pid == '0) || (pid == cur_pid);
    hit    = valid && pid_ok && ((ea & mask) == epn);
    ra     = (rpn & mask) | (ea & ~mask);
  end

endmodule

// File: rtl/ztlb_first_hit.sv
module ztlb_first_hit #(
  parameter int ENTRIES = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hits,
  output logic               any,
  output logic [IDXW-1:0]    idx
);

  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hits[i]) idx = IDXW'(i);
  end

endmodule

// File: rtl/ztlb_zone_gate.sv
module ztlb_zone_gate (
  input  logic [1:0] code,
  input  logic       fetch,
  input  logic       store,
  input  logic       user,
  input  logic       ent_exec,
  input  logic       ent_write,
  output logic       grant,
  output logic       perm_rd,
  output logic       perm_wr
);

  always_comb begin
    grant   = 1'b0;
    perm_rd = 1'b0;
    perm_wr = 1'b0;
    if (code == 2'd3) begin
      grant   = 1'b1;
      perm_rd = 1'b1;
      perm_wr = 1'b1;
    end else if (!(code == 2'd0 && user)) begin
      if (fetch)      grant = ent_exec;
      else if (store) grant = ent_write;
      else            grant = 1'b1;
      if (grant) begin
        perm_rd = 1'b1;
        perm_wr = ent_write;
      end
    end
  end

endmodule

// File: rtl/ztlb_xlate.sv
module ztlb_xlate
  import ztlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_valid,
  input  logic [2:0]      wr_size,
  input  logic [PIDW-1:0] wr_pid,
  input  logic [3:0]      wr_zone,
  input  logic [31:0]     wr_epn,
  input  logic [31:0]     wr_rpn,
  input  logic            wr_exec,
  input  logic            wr_write,
  input  logic            req,
  input  logic [31:0]     req_ea,
  input  logic            req_fetch,
  input  logic            req_store,
  input  logic            req_user,
  input  logic [PIDW-1:0] cur_pid,
  input  logic [31:0]     zone_prot,
  input  logic [31:0]     msr_in,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IDXW-1:0] rsp_idx,
  output logic [31:0]     rsp_ra,
  output logic            rsp_rd,
  output logic            rsp_wr,
  output logic [2:0]      rsp_fault,
  output logic [31:0]     fault_addr,
  output logic [31:0]     fault_status,
  output logic [31:0]     msr_out
);

  logic              valid_q [ENTRIES];
  logic [SZ_W-1:0]   size_q  [ENTRIES];
  logic [PIDW-1:0]   pid_q   [ENTRIES];
  logic [ZONE_W-1:0] zone_q  [ENTRIES];
  logic [31:0]       epn_q   [ENTRIES];
  logic [31:0]       rpn_q   [ENTRIES];
  logic              exec_q  [ENTRIES];
  logic              write_q [ENTRIES];

  ztlb_entry_store #(.ENTRIES(ENTRIES), .PIDW(PIDW)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_size(wr_size), .wr_pid(wr_pid),
    .wr_zone(wr_zone), .wr_epn(wr_epn), .wr_rpn(wr_rpn),
    .wr_exec(wr_exec), .wr_write(wr_write),
    .valid_q(valid_q), .size_q(size_q), .pid_q(pid_q), .zone_q(zone_q),
    .epn_q(epn_q), .rpn_q(rpn_q), .exec_q(exec_q), .write_q(write_q)
  );

  logic [ENTRIES-1:0] hits;
  logic [31:0]        ra_each [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    ztlb_entry_match #(.PIDW(PIDW)) match_i (
      .valid(valid_q[g]), .size(size_q[g]), .pid(pid_q[g]),
      .epn(epn_q[g]), .rpn(rpn_q[g]), .ea(req_ea), .cur_pid(cur_pid),
      .hit(hits[g]), .ra(ra_each[g])
    );
  end

  logic            any_hit;
  logic [IDXW-1:0] sel;

  ztlb_first_hit #(.ENTRIES(ENTRIES)) first_i (
    .hits(hits), .any(any_hit), .idx(sel)
  );

  logic [ZONE_W-1:0] zone_sel;
  logic [4:0]        code_lsb;
  logic [1:0]        zcode;

  always_comb begin
    zone_sel = zone_q[sel];
    code_lsb = 5'd30 - {zone_sel, 1'b0};
    zcode    = zone_prot[code_lsb +: 2];
  end

  logic grant, g_rd, g_wr;

  ztlb_zone_gate gate_i (
    .code(zcode), .fetch(req_fetch), .store(req_store), .user(req_user),
    .ent_exec(exec_q[sel]), .ent_write(write_q[sel]),
    .grant(grant), .perm_rd(g_rd), .perm_wr(g_wr)
  );

  fault_e fault_d;

  always_comb begin
    if (!any_hit)    fault_d = req_fetch ? FLT_IMISS : FLT_DMISS;
    else if (!grant) fault_d = req_fetch ? FLT_IPROT : FLT_DPROT;
    else             fault_d = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_idx      <= '0;
      rsp_ra       <= '0;
      rsp_rd       <= 1'b0;
      rsp_wr       <= 1'b0;
      rsp_fault    <= 3'd0;
      fault_addr   <= '0;
      fault_status <= '0;
      msr_out      <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_hit   <= any_hit;
        rsp_idx   <= any_hit ? sel : '0;
        rsp_ra    <= any_hit ? ra_each[sel] : '0;
        rsp_rd    <= any_hit && grant && g_rd;
        rsp_wr    <= any_hit && grant && g_wr;
        rsp_fault <= fault_d;
        if (!any_hit) begin
          fault_addr   <= req_ea;
          fault_status <= (!req_fetch && req_store) ? STORE_MISS_STATUS : 32'd0;
          msr_out      <= {16'h0000, msr_in[15:0]};
        end else begin
          msr_out      <= msr_in;
        end
      end
    end
  end

endmodule

// File: rtl/ztlb_xlate_chk.sv
module ztlb_xlate_chk #(
  parameter int ENTRIES = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic [31:0]     req_ea,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [IDXW-1:0] rsp_idx,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic [2:0]      rsp_fault,
  input logic [31:0]     fault_addr,
  input logic [31:0]     fault_status,
  input logic [31:0]     msr_out
);

  logic is_miss;
  assign is_miss = rsp_valid && (rsp_fault == 3'd1 || rsp_fault == 3'd2);

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);

  assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);

  assert_miss_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
    is_miss |-> (!rsp_hit && rsp_idx == '0));

  assert_miss_addr_R9: assert property (@(posedge clk) disable iff (rst)
    is_miss |-> fault_addr == $past(req_ea));

  assert_imiss_status_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd1) |-> fault_status == 32'd0);

  assert_miss_msr_R11: assert property (@(posedge clk) disable iff (rst)
    is_miss |-> msr_out[31:16] == 16'h0000);

  assert_fault_no_perm_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (!rsp_rd && !rsp_wr));

  assert_wr_has_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr) |-> rsp_rd);

  assert_fault_code_range_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault <= 3'd4);

endmodule

bind ztlb_xlate ztlb_xlate_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst(rst), .req(req), .req_ea(req_ea),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
  .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_fault(rsp_fault),
  .fault_addr(fault_addr), .fault_status(fault_status), .msr_out(msr_out)
);

// File: tb/ztlb_xlate_tb_top.sv
`timescale 1ns/1ps
module ztlb_xlate_tb_top;

  localparam int ENTRIES = 8;
  localparam int PIDW    = 8;
  localparam int IDXW    = $clog2(ENTRIES);

  logic            clk = 1'b0;
  logic            rst;
  logic            wr_en, wr_valid, wr_exec, wr_write;
  logic [IDXW-1:0] wr_idx;
  logic [2:0]      wr_size;
  logic [PIDW-1:0] wr_pid;
  logic [3:0]      wr_zone;
  logic [31:0]     wr_epn, wr_rpn;
  logic            req, req_fetch, req_store, req_user;
  logic [31:0]     req_ea, zone_prot, msr_in;
  logic [PIDW-1:0] cur_pid;
  logic            rsp_valid, rsp_hit, rsp_rd, rsp_wr;
  logic [IDXW-1:0] rsp_idx;
  logic [31:0]     rsp_ra, fault_addr, fault_status, msr_out;
  logic [2:0]      rsp_fault;

  always #4 clk = ~clk;

  ztlb_xlate #(.ENTRIES(ENTRIES), .PIDW(PIDW)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the table
  logic            m_valid [ENTRIES];
  logic [2:0]      m_size  [ENTRIES];
  logic [PIDW-1:0] m_pid   [ENTRIES];
  logic [3:0]      m_zone  [ENTRIES];
  logic [31:0]     m_epn   [ENTRIES];
  logic [31:0]     m_rpn   [ENTRIES];
  logic            m_ex    [ENTRIES];
  logic            m_wr    [ENTRIES];

  // expected outputs
  logic            e_hit, e_rd, e_wr;
  logic [IDXW-1:0] e_idx;
  logic [31:0]     e_ra, e_faddr, e_stat, e_msr;
  logic [2:0]      e_fault;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] msk(input logic [2:0] s);
    return ~((32'd1 << (10 + 2 * int'(s))) - 32'd1);
  endfunction

  function automatic void model_lookup(input logic [31:0] ea, input logic f, input logic st,
                                       input logic u, input logic [PIDW-1:0] p,
                                       input logic [31:0] zp, input logic [31:0] ms);
    int found;
    logic [1:0] code;
    logic ok;
    found = -1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m_valid[i] && (m_pid[i] == 0 || m_pid[i] == p) && ((ea & msk(m_size[i])) == m_epn[i]))
        found = i;
    e_rd = 0; e_wr = 0;
    if (found < 0) begin
      e_hit = 0; e_idx = '0; e_ra = 0;
      e_fault = f ? 3'd1 : 3'd2;
      e_faddr = ea;
      e_stat  = (!f && st) ? 32'h0080_0000 : 32'd0;
      e_msr   = ms & 32'h0000_FFFF;
    end else begin
      e_hit = 1; e_idx = IDXW'(found);
      e_ra  = (m_rpn[found] & msk(m_size[found])) | (ea & ~msk(m_size[found]));
      code  = 2'((zp >> (30 - 2 * int'(m_zone[found]))) & 32'd3);
      e_msr = ms;
      if (code == 2'd3) begin
        ok = 1; e_rd = 1; e_wr = 1;
      end else if (code == 2'd0 && u) begin
        ok = 0;
      end else begin
        ok = f ? m_ex[found] : (st ? m_wr[found] : 1'b1);
        if (ok) begin e_rd = 1; e_wr = m_wr[found]; end
      end
      e_fault = ok ? 3'd0 : (f ? 3'd3 : 3'd4);
    end
  endfunction

  function automatic void model_write(input int i, input logic v, input logic [2:0] s,
                                      input logic [PIDW-1:0] p, input logic [3:0] z,
                                      input logic [31:0] ep, input logic [31:0] rp,
                                      input logic x, input logic w);
    m_valid[i] = v; m_size[i] = s; m_pid[i] = p; m_zone[i] = z;
    m_epn[i] = ep & msk(s); m_rpn[i] = rp; m_ex[i] = x; m_wr[i] = w;
  endfunction

  logic [31:0] l_ea, l_zp, l_ms;
  logic        l_f, l_st, l_u;
  logic [PIDW-1:0] l_pid;

  task automatic set_look(input logic [31:0] ea, input logic f, input logic st, input logic u,
                          input logic [PIDW-1:0] p, input logic [31:0] zp, input logic [31:0] ms);
    l_ea = ea; l_f = f; l_st = st; l_u = u; l_pid = p; l_zp = zp; l_ms = ms;
    req = 1; req_ea = ea; req_fetch = f; req_store = st; req_user = u;
    cur_pid = p; zone_prot = zp; msr_in = ms;
  endtask

  task automatic set_write(input int i, input logic v, input logic [2:0] s, input logic [PIDW-1:0] p,
                           input logic [3:0] z, input logic [31:0] ep, input logic [31:0] rp,
                           input logic x, input logic w);
    wr_en = 1; wr_idx = IDXW'(i); wr_valid = v; wr_size = s; wr_pid = p; wr_zone = z;
    wr_epn = ep; wr_rpn = rp; wr_exec = x; wr_write = w;
  endtask

  task automatic check_all();
    chk(rsp_valid == 1'b1, "R12 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_hit == e_hit && rsp_idx == e_idx, "R1 hit/idx", {rsp_hit, 31'(rsp_idx)}, {e_hit, 31'(e_idx)});
    chk(rsp_ra == e_ra, "R4 real address", rsp_ra, e_ra);
    chk(rsp_rd == e_rd && rsp_wr == e_wr, "R7 permissions", {rsp_rd, rsp_wr}, {e_rd, e_wr});
    chk(rsp_fault == e_fault, "R6 fault class", 32'(rsp_fault), 32'(e_fault));
    chk(fault_addr == e_faddr, "R9 fault address", fault_addr, e_faddr);
    chk(fault_status == e_stat, "R10 fault status", fault_status, e_stat);
    chk(msr_out == e_msr, "R11 state word", msr_out, e_msr);
  endtask

  task automatic do_write(input int i, input logic v, input logic [2:0] s, input logic [PIDW-1:0] p,
                          input logic [3:0] z, input logic [31:0] ep, input logic [31:0] rp,
                          input logic x, input logic w);
    @(negedge clk);
    set_write(i, v, s, p, z, ep, rp, x, w);
    @(negedge clk);
    wr_en = 0;
    model_write(i, v, s, p, z, ep, rp, x, w);
  endtask

  task automatic do_look(input logic [31:0] ea, input logic f, input logic st, input logic u,
                         input logic [PIDW-1:0] p, input logic [31:0] zp, input logic [31:0] ms);
    @(negedge clk);
    set_look(ea, f, st, u, p, zp, ms);
    @(negedge clk);
    req = 0;
    model_lookup(l_ea, l_f, l_st, l_u, l_pid, l_zp, l_ms);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; req = 0;
    wr_idx = '0; wr_valid = 0; wr_size = 0; wr_pid = 0; wr_zone = 0;
    wr_epn = 0; wr_rpn = 0; wr_exec = 0; wr_write = 0;
    req_ea = 0; req_fetch = 0; req_store = 0; req_user = 0;
    cur_pid = 0; zone_prot = 0; msr_in = 0;
    for (int i = 0; i < ENTRIES; i++) model_write(i, 0, 0, 0, 0, 0, 0, 0, 0);
    e_faddr = 0; e_stat = 0; e_msr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 0 && rsp_hit == 0 && rsp_fault == 0, "R12 reset outputs",
        {rsp_valid, rsp_hit, 27'd0, rsp_fault}, 32'd0);
    chk(fault_addr == 0 && fault_status == 0 && msr_out == 0, "R12 reset capture",
        fault_addr | fault_status | msr_out, 32'd0);
    // R12: empty table misses everything after reset
    do_look(32'h1234_5678, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    chk(rsp_fault == 3'd2 && fault_status == 32'h0080_0000, "R10 store miss status",
        fault_status, 32'h0080_0000);
    chk(msr_out == 32'h0000_BEEF, "R11 upper half cleared", msr_out, 32'h0000_BEEF);
    do_look(32'h0000_4000, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'h1234_5678);
    chk(rsp_fault == 3'd1 && fault_status == 0, "R10 fetch miss status", fault_status, 32'd0);

    // R1 priority: entries 2 and 5 cover the same page
    do_write(5, 1, 1, 0, 0, 32'h4000_1000, 32'h0005_0000, 1, 1);
    do_write(2, 1, 1, 0, 0, 32'h4000_1000, 32'h0002_0000, 1, 1);
    do_look(32'h4000_1234, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h1);
    chk(rsp_idx == 2, "R1 lowest index wins", 32'(rsp_idx), 32'd2);
    // R12: outputs hold while idle
    @(negedge clk);
    chk(rsp_valid == 0 && rsp_idx == 2 && rsp_ra == 32'h0002_0234, "R12 hold when idle", rsp_ra, 32'h0002_0234);
    do_write(2, 0, 1, 0, 0, 32'h4000_1000, 32'h0002_0000, 1, 1);
    do_look(32'h4000_1234, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h1);
    chk(rsp_idx == 5, "R1 invalid entry skipped", 32'(rsp_idx), 32'd5);

    // R2 process ID
    do_write(0, 1, 0, 8'd0, 0, 32'h2000_0400, 32'h0000_8000, 1, 0);
    do_write(1, 1, 0, 8'd3, 0, 32'h2000_0800, 32'h0000_9000, 1, 0);
    do_look(32'h2000_0404, 0, 0, 0, 8'd7, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 1 && rsp_idx == 0, "R2 pid 0 matches any", 32'(rsp_hit), 32'd1);
    do_look(32'h2000_0804, 0, 0, 0, 8'd4, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 0, "R2 pid mismatch misses", 32'(rsp_hit), 32'd0);
    do_look(32'h2000_0804, 0, 0, 0, 8'd3, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 1 && rsp_idx == 1, "R2 pid equal hits", 32'(rsp_hit), 32'd1);

    // R3 page size: 16 MiB page ignores bit 20, 1 KiB page does not ignore bit 10
    do_write(3, 1, 7, 0, 0, 32'h7712_3456, 32'hAB00_0000, 1, 1);
    do_look(32'h77F0_0001, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 1 && rsp_ra == 32'hABF0_0001, "R3 large page / R4 ra", rsp_ra, 32'hABF0_0001);
    do_look(32'h2000_0004, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 0, "R3 small page boundary", 32'(rsp_hit), 32'd0);

    // R5/R6/R8 zones: entry 4 in zone 15, entry 6 in zone 0
    do_write(4, 1, 1, 0, 4'd15, 32'h5000_0000, 32'h0001_0000, 0, 0);
    do_look(32'h5000_0010, 1, 0, 1, 0, 32'h0000_0003, 0);
    chk(rsp_fault == 0 && rsp_rd && rsp_wr, "R8 code 3 overrides bits / R5 zone 15", 32'(rsp_fault), 32'd0);
    do_look(32'h5000_0010, 0, 0, 1, 0, 32'hFFFF_FFFC, 0);
    chk(rsp_fault == 3'd4 && !rsp_rd, "R6 user denied in code 0 / R5 zone 15", 32'(rsp_fault), 32'd4);
    do_look(32'h5000_0010, 0, 0, 0, 0, 32'hFFFF_FFFC, 0);
    chk(rsp_fault == 0 && rsp_rd && !rsp_wr, "R6 supervisor code 0 acts as 1", 32'(rsp_fault), 32'd0);
    do_look(32'h5000_0010, 1, 0, 0, 0, 32'hFFFF_FFFD, 0);
    chk(rsp_fault == 3'd3, "R7 fetch needs exec bit", 32'(rsp_fault), 32'd3);
    do_look(32'h5000_0010, 0, 1, 0, 0, 32'hFFFF_FFFE, 0);
    chk(rsp_fault == 3'd4, "R7 store needs write bit", 32'(rsp_fault), 32'd4);
    do_write(6, 1, 1, 0, 4'd0, 32'h6000_0000, 32'h0002_0000, 0, 1);
    do_look(32'h6000_0020, 0, 1, 1, 0, 32'h3FFF_FFFF, 0);
    chk(rsp_fault == 3'd4, "R5 zone 0 reads top bits", 32'(rsp_fault), 32'd4);
    do_look(32'h6000_0020, 0, 1, 1, 0, 32'h4000_0000, 0);
    chk(rsp_fault == 0 && rsp_wr, "R7 store granted with write bit", 32'(rsp_fault), 32'd0);

    // R13 same-cycle write and lookup
    @(negedge clk);
    set_look(32'h6000_0020, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
    set_write(6, 0, 1, 0, 0, 32'h6000_0000, 32'h0002_0000, 0, 1);
    @(negedge clk);
    req = 0; wr_en = 0;
    model_lookup(l_ea, l_f, l_st, l_u, l_pid, l_zp, l_ms);
    model_write(6, 0, 1, 0, 0, 32'h6000_0000, 32'h0002_0000, 0, 1);
    check_all();
    chk(rsp_hit == 1 && rsp_idx == 6, "R13 lookup sees old entry", 32'(rsp_idx), 32'd6);
    do_look(32'h6000_0020, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
    chk(rsp_hit == 0, "R13 next lookup sees write", 32'(rsp_hit), 32'd0);

    // random traffic, writes and lookups overlapping
    for (int n = 0; n < 1500; n++) begin
      int k;
      logic [31:0] ea;
      k = int'($urandom_range(ENTRIES - 1));
      @(negedge clk);
      req = 0; wr_en = 0;
      if ($urandom_range(9) < 4) begin
        logic [2:0] s;
        s = 3'($urandom_range(3));
        set_write(int'($urandom_range(ENTRIES - 1)), ($urandom_range(4) != 0), s,
                  PIDW'($urandom_range(2)), 4'($urandom), $urandom & 32'h0FFF_FFFF,
                  $urandom, 1'($urandom), 1'($urandom));
      end
      if ($urandom_range(9) < 7) begin
        ea = ($urandom_range(3) != 0) ? (m_epn[k] | ($urandom & ~msk(m_size[k]))) : $urandom;
        set_look(ea, 1'($urandom), 1'($urandom), 1'($urandom), PIDW'($urandom_range(2)),
                 $urandom, $urandom);
      end
      @(negedge clk);
      if (req) begin
        req = 0;
        model_lookup(l_ea, l_f, l_st, l_u, l_pid, l_zp, l_ms);
        if (wr_en) model_write(int'(wr_idx), wr_valid, wr_size, wr_pid, wr_zone, wr_epn, wr_rpn, wr_exec, wr_write);
        wr_en = 0;
        check_all();
      end else begin
        if (wr_en) model_write(int'(wr_idx), wr_valid, wr_size, wr_pid, wr_zone, wr_epn, wr_rpn, wr_exec, wr_write);
        wr_en = 0;
        chk(rsp_valid == 0, "R12 no response without request", 32'(rsp_valid), 32'd0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule